// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the counting core of an integer-N frequency synthesizer, written as synchronous logic. Its clock stands for the oscillator being divided: every rising edge is one input cycle. A prescaler divides that clock by 10 or by 11. A swallow counter decides which of the two ratios each prescaler cycle uses, and a main counter groups the prescaler cycles into one output period. The total ratio is 10 × (M + 1) + A. When the prescaler is bypassed, every input cycle advances the main counter directly.

A second chain divides a reference. The reference arrives as a one-cycle strobe, one per reference period, and a reference counter emits one output pulse for every R + 1 strobes. Divider settings can change at any moment. A new setting is taken only when the counter it affects reloads, so a period already in progress always ends with the old setting.

A monitor output can carry the modulus-select signal or the prescaler cycle tick. A single input silences both divided outputs.

Top module: `pswallow_divider`

## Requirements
- R1: With `pre_en_n` low, consecutive `fp` pulses are 10 × (M + 1) + A clock cycles apart, for M ≥ 1 and A ≤ M + 1.
- R2: Within each main period the first A prescaler cycles last 11 clocks and the remaining ones last 10 clocks. `msel` is high for exactly 11 × A clock cycles per period, counting from the `fp` cycle up to the cycle before the next `fp`.
- R3: With `pre_en_n` high the prescaler is bypassed, consecutive `fp` pulses are M + 1 cycles apart, and `a_val` has no effect.
- R4: A change of `m_val`, `a_val` or `pre_en_n` leaves the period in progress at its old length. The new values apply from the main reload that ends that period.
- R5: `fc` is high only in a cycle where `ref_pulse` is high, once every R + 1 reference strobes. When R = 0, `fc` equals `ref_pulse`.
- R6: A change of `r_val` applies from the reference reload that follows it. The reload happens in the cycle where `fc` is high.
- R7: `fp` is a registered single-cycle pulse. It rises one clock after the edge where the main counter reloads.
- R8: `dout` follows `mon_sel`. The value 2'b01 selects `msel`, 2'b10 selects the prescaler cycle tick `pre_out` (M + 1 ticks per period), and 2'b00 or 2'b11 hold `dout` at 0.
- R9: While `out_dis` is high, `fp` and `fc` stay low.
- R10: While `rst_n` is low, `fp` and `fc` are low. In the first cycle after release, `fp` is high because the main chain reloads on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock; one edge per input cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_en_n | input | 1 | Prescaler enable, active low; high selects bypass |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow counter setting A |
| r_val | input | 6 | Reference counter setting R |
| ref_pulse | input | 1 | One-cycle strobe per reference period |
| mon_sel | input | 2 | Monitor source select for `dout` |
| out_dis | input | 1 | Forces `fp` and `fc` low |
| fp | output | 1 | Divided main pulse |
| fc | output | 1 | Divided reference pulse |
| msel | output | 1 | Modulus select; high for a divide-by-11 prescaler cycle |
| pre_out | output | 1 | Prescaler cycle tick |
| dout | output | 1 | Monitor output |

## Verification
`fp` rises one cycle after the reload edge. The bench therefore measures the spacing between rising pulses and does not depend on the absolute arrival time. After each settings change, the first interval is scored against the old ratio and the following intervals against the new one. `fc`, `msel`, `pre_out` and `dout` settle within the same cycle as the state or strobe that causes them. The bench samples them one time unit after the falling edge. It counts `msel` and `dout` over a window that opens on an `fp` cycle and closes just before the next one. It counts reference strobes up to and including the `fc` that ends each reference period.

// File: rtl/pswallow_pkg.sv
// Shared defaults and the monitor select encoding for the pulse-swallow divider.
package pswallow_pkg;
    parameter int DEF_M_W    = 9;   // main counter width
    parameter int DEF_A_W    = 4;   // swallow counter width
    parameter int DEF_R_W    = 6;   // reference counter width
    parameter int DEF_BASE   = 10;  // lower prescaler modulus (upper is +1)

    typedef enum logic [1:0] {
        MON_OFF  = 2'b00,
        MON_MSEL = 2'b01,
        MON_TICK = 2'b10,
        MON_RSV  = 2'b11
    } mon_sel_e;
endpackage

// File: rtl/pre_div.sv
// Dual-modulus prescaler: divides the clock by BASE or BASE+1 per cycle.
// Assumes mod11_next is valid whenever tick is high; bypass forces a tick
// every clock so the next stage sees the undivided input.
module pre_div #(
    parameter int BASE = 10,
    localparam int PC_W = $clog2(BASE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic mod11_next,
    output logic tick,
    output logic msel
);
    logic [PC_W-1:0] pcnt;

    // Prescaler cycle ends when the down-counter reaches zero or in bypass.
    assign tick = bypass || (pcnt == '0);

    // Reload the cycle length at each tick, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            msel <= 1'b0;
        end else if (tick) begin
            pcnt <= mod11_next ? PC_W'(BASE) : PC_W'(BASE - 1);
            msel <= mod11_next;
        end else begin
            pcnt <= pcnt - PC_W'(1);
        end
    end
endmodule

// File: rtl/swallow_ctl.sv
// Main and swallow counters. Counts prescaler ticks, decides the modulus of
// the next prescaler cycle and captures new settings only at main reload.
// Assumes M >= 1 and A <= M + 1 for the ratio to hold.
module swallow_ctl #(
    parameter int M_W = 9,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           msel,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           byp_in,
    output logic           reload,
    output logic           bypass_q,
    output logic           mod11_next
);
    logic [M_W-1:0] mcnt;
    logic [A_W-1:0] acnt;
    logic [A_W-1:0] acnt_dec;

    // Swallow count after this prescaler cycle, saturating at zero.
    assign acnt_dec = (acnt != '0) ? acnt - A_W'(1) : '0;
    // Main period ends on the tick that finds the main counter at zero.
    assign reload = tick && (mcnt == '0);
    // Modulus of the prescaler cycle that starts after this tick.
    assign mod11_next = reload ? (!byp_in && (a_in != '0)) : (acnt_dec != '0);

    // Counter update: capture settings at reload, step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt     <= '0;
            acnt     <= '0;
            bypass_q <= 1'b0;
        end else if (reload) begin
            mcnt     <= m_in;
            acnt     <= byp_in ? '0 : a_in;
            bypass_q <= byp_in;
        end else if (tick) begin
            mcnt <= mcnt - M_W'(1);
            acnt <= acnt_dec;
        end
    end

    a_r2_msel_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        msel == (acnt != '0))
        else $error("R2: prescaler modulus disagrees with swallow count");
    a_r3_bypass_no_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_q |-> (!msel && acnt == '0))
        else $error("R3: swallowing while bypassed");
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(bypass_q))
        else $error("R4: mode changed outside reload");
    a_r7_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && m_in != '0) |=> !reload)
        else $error("R7: reload lasted more than one cycle");
endmodule

// File: rtl/ref_div.sv
// Reference divider: one terminal pulse per R+1 reference strobes.
// R = 0 passes every strobe. A new R is taken at the terminal strobe.
module ref_div #(
    parameter int R_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_pulse,
    input  logic [R_W-1:0] r_in,
    output logic           term
);
    logic [R_W-1:0] rcnt;

    // Terminal strobe: a reference strobe while the counter sits at zero.
    assign term = rst_n && ref_pulse && (rcnt == '0);

    // Count strobes down, reload from the setting at the terminal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt <= '0;
        end else if (ref_pulse) begin
            rcnt <= (rcnt == '0) ? r_in : rcnt - R_W'(1);
        end
    end

    a_r5_fc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (term && r_in != '0) |=> !term)
        else $error("R5: reference terminal repeated");
endmodule

// File: rtl/pswallow_divider.sv
// Top of the pulse-swallow divider: prescaler, swallow/main counters,
// reference counter, output gating and monitor mux.
// Assumes ref_pulse is a single-cycle strobe synchronous to clk.
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int M_W  = DEF_M_W,
    parameter int A_W  = DEF_A_W,
    parameter int R_W  = DEF_R_W,
    parameter int BASE = DEF_BASE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_en_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic [R_W-1:0] r_val,
    input  logic           ref_pulse,
    input  logic [1:0]     mon_sel,
    input  logic           out_dis,
    output logic           fp,
    output logic           fc,
    output logic           msel,
    output logic           pre_out,
    output logic           dout
);
    logic     tick;
    logic     reload;
    logic     bypass_q;
    logic     mod11_next;
    logic     ref_term;
    logic     fp_q;
    mon_sel_e sel;

    pre_div #(.BASE(BASE)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass_q),
        .mod11_next (mod11_next),
        .tick       (tick),
        .msel       (msel)
    );

    swallow_ctl #(.M_W(M_W), .A_W(A_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .msel       (msel),
        .m_in       (m_val),
        .a_in       (a_val),
        .byp_in     (pre_en_n),
        .reload     (reload),
        .bypass_q   (bypass_q),
        .mod11_next (mod11_next)
    );

    ref_div #(.R_W(R_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .r_in      (r_val),
        .term      (ref_term)
    );

    // Register the main pulse so fp is clean for one cycle per period.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_q <= 1'b0;
        else        fp_q <= reload;
    end

    // Output gating for the two divided outputs.
    assign fp      = fp_q && !out_dis;
    assign fc      = ref_term && !out_dis;
    assign pre_out = tick;
    assign sel     = mon_sel_e'(mon_sel);

    // Monitor source selection.
    always_comb begin
        unique case (sel)
            MON_MSEL: dout = msel;
            MON_TICK: dout = tick;
            default:  dout = 1'b0;
        endcase
    end

    a_r9_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (!fp && !fc))
        else $error("R9: output active while disabled");
endmodule

// File: tb/test_pswallow_divider.sv
module test_pswallow_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_en_n = 1'b0;
    logic [8:0] m_val = 9'd4;
    logic [3:0] a_val = 4'd2;
    logic [5:0] r_val = 6'd2;
    logic       ref_pulse = 1'b0;
    logic [1:0] mon_sel = 2'b00;
    logic       out_dis = 1'b0;
    logic       fp, fc, msel, pre_out, dout;

    int checks = 0;
    int errors = 0;
    int fp_seen = 0;
    int gap = 0;
    int cur_ratio = 52;
    int exp_q[$];
    string tag_q[$];

    pswallow_divider i_pswallow_divider (
        .clk(clk), .rst_n(rst_n), .pre_en_n(pre_en_n), .m_val(m_val),
        .a_val(a_val), .r_val(r_val), .ref_pulse(ref_pulse), .mon_sel(mon_sel),
        .out_dis(out_dis), .fp(fp), .fc(fc), .msel(msel), .pre_out(pre_out),
        .dout(dout)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic smp();
        @(negedge clk);
        #1;
    endtask

    function automatic int ratio(input int m, input int a, input bit byp);
        return byp ? m + 1 : 10 * (m + 1) + a;
    endfunction

    // Reference strobe: one cycle in five, driven at the falling edge.
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0;
        end
    end

    // Monitor: measures fp spacing and scores it against the queue.
    always begin
        smp();
        gap++;
        if (fp) begin
            if (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(gap == e, t, gap, e);
            end
            gap = 0;
            fp_seen++;
        end
    end

    task automatic wait_fp();
        int k;
        k = fp_seen;
        wait (fp_seen > k);
    endtask

    // Driver: scores the period in flight at the old ratio, then n new ones.
    task automatic set_cfg(input int m, input int a, input bit byp, input int n,
                           input string tag);
        wait_fp();
        exp_q.push_back(cur_ratio);
        tag_q.push_back("R4 old ratio kept");
        @(negedge clk);
        m_val = 9'(m);
        a_val = 4'(a);
        pre_en_n = byp;
        wait_fp();
        cur_ratio = ratio(m, a, byp);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(cur_ratio);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < n; i++) wait_fp();
    endtask

    // Counts dout highs over one main period starting on an fp cycle.
    task automatic count_dout(input logic [1:0] sel, input int exp, input string tag);
        int c;
        @(negedge clk);
        mon_sel = sel;
        do smp(); while (!fp);
        c = int'(dout);
        forever begin
            smp();
            if (fp) break;
            c += int'(dout);
        end
        chk(c == exp, tag, c, exp);
    endtask

    // Sets R and counts strobes per reference period, twice.
    task automatic check_ref(input int r);
        int c;
        @(negedge clk);
        r_val = 6'(r);
        do smp(); while (!fc);
        for (int p = 0; p < 2; p++) begin
            c = 0;
            forever begin
                smp();
                if (ref_pulse) c++;
                if (fc) begin
                    chk(ref_pulse == 1'b1, "R5 fc with strobe", int'(ref_pulse), 1);
                    break;
                end
            end
            chk(c == r + 1, p == 0 ? "R6 new R applied" : "R5 fc spacing", c, r + 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int m;
        int a;
        // R10: quiet outputs while reset is held, strobes included.
        c = 0;
        for (int i = 0; i < 8; i++) begin
            smp();
            c += int'(fp) + int'(fc);
        end
        chk(c == 0, "R10 reset quiet", c, 0);
        @(negedge clk);
        rst_n = 1'b1;
        smp();
        chk(fp == 1'b1, "R10 first reload", int'(fp), 1);

        // R1: prescaler ratios, including the A = M + 1 limit.
        set_cfg(1, 0, 1'b0, 2, "R1 M=1 A=0");
        set_cfg(1, 2, 1'b0, 2, "R1 M=1 A=2");
        set_cfg(3, 4, 1'b0, 2, "R1 M=3 A=4");
        set_cfg(300, 15, 1'b0, 2, "R1 M=300 A=15");
        for (int i = 0; i < 8; i++) begin
            m = 1 + int'($urandom % 60);
            a = int'($urandom % ((m + 1 > 15 ? 15 : m + 1) + 1));
            set_cfg(m, a, 1'b0, 2, "R1 random");
        end

        // R3: bypass, with A changed to show it has no effect.
        set_cfg(1, 0, 1'b1, 2, "R3 bypass M=1");
        set_cfg(7, 9, 1'b1, 2, "R3 bypass M=7 A=9");
        set_cfg(7, 0, 1'b1, 2, "R3 bypass M=7 A=0");
        set_cfg(5, 3, 1'b0, 2, "R4 back to prescaler");

        // R2 and R8: monitor sources over one period of M=5 A=3.
        count_dout(2'b01, 33, "R2 msel cycles");
        count_dout(2'b10, 6, "R8 tick count");
        count_dout(2'b00, 0, "R8 off");
        count_dout(2'b11, 0, "R8 reserved");
        @(negedge clk);
        mon_sel = 2'b00;

        // R7: fp is one cycle wide.
        do smp(); while (!fp);
        smp();
        chk(fp == 1'b0, "R7 single pulse", int'(fp), 0);

        // R5 and R6: reference division.
        check_ref(3);
        check_ref(7);
        check_ref(0);
        c = 0;
        for (int i = 0; i < 30; i++) begin
            smp();
            if (fc != ref_pulse) c++;
        end
        chk(c == 0, "R5 R=0 passthrough", c, 0);

        // R9: outputs held low while disabled.
        @(negedge clk);
        out_dis = 1'b1;
        c = 0;
        for (int i = 0; i < 200; i++) begin
            smp();
            c += int'(fp) + int'(fc);
        end
        chk(c == 0, "R9 outputs disabled", c, 0);
        @(negedge clk);
        out_dis = 1'b0;
        c = 0;
        for (int i = 0; i < 200; i++) begin
            smp();
            c += int'(fp);
        end
        chk(c > 0, "R9 outputs restored", c, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule